// File: doc/BRIEF.md
# Serial Receiver with Stop-Bit Checking and Address Filtering

This block is the receive half of an asynchronous serial port that carries either eight or nine data bits per frame. An oversampling tick, sixteen per bit time, drives a small state machine. It finds the falling edge of a start bit, confirms the start bit at mid-bit, collects the data bits least significant first and then looks at the stop bit. A finished frame is placed on a byte output, and a sticky receive-complete flag is raised.

Two optional behaviours are selected by control inputs. With stop-bit checking on, the complete flag moves from the last data bit to the stop bit, and a low stop bit raises a sticky framing-error flag. In nine-bit mode with address filtering on, a node ignores data frames. It accepts an address frame (ninth bit high) only when the byte matches its own masked address or the broadcast pattern formed from its address and mask. Software clears both flags through one-cycle clear inputs.

Top module: `urx_top`

## Requirements
- R1: After reset `rxDone`, `frameErr`, `rxNinth` and `rxByte` are all zero.
- R2: A frame is a low start bit, the data bits least significant first (8 when `nineBit`=0, 9 when `nineBit`=1), then a stop bit. An accepted frame loads bits 7..0 into `rxByte`, loads the ninth bit into `rxNinth` (0 in 8-bit mode) and sets `rxDone`.
- R3: Each bit lasts 16 `baudTick` periods. Its value is the majority of the samples at ticks 7, 8 and 9 of the bit cell, so one deviating sample among them does not change the bit.
- R4: A falling edge whose majority at mid-bit is high is a false start. It delivers no frame, and the receiver then takes the next valid frame.
- R5: With `frameChk`=0, `rxDone` rises at the decision point of the last data bit. With `frameChk`=1 it rises at the stop-bit decision point, exactly 16 ticks later.
- R6: With `frameChk`=1, a stop bit sampled low sets `frameErr`. The frame is still delivered under the other acceptance rules. A high stop bit leaves `frameErr` at 0.
- R7: `frameErr` stays set through later frames with valid stop bits. Only `errClr` or reset clears it, and a new framing error in the same cycle as `errClr` wins.
- R8: `rxDone` stays set until `rdyClr`. A frame that completes while `rxDone` is set is discarded and `rxByte` is unchanged. A frame that completes with `rxDone` clear while `rdyClr` is high still sets `rxDone`.
- R9: With `nineBit`=1 and `addrFilter`=1, a frame whose ninth bit is 0 is discarded.
- R10: With `nineBit`=1 and `addrFilter`=1, a frame whose ninth bit is 1 is accepted only if ((byte XOR `slaveAddr`) AND `slaveMask`) is 0, or if byte AND (`slaveAddr` OR `slaveMask`) equals (`slaveAddr` OR `slaveMask`).
- R11: `addrFilter` has no effect in 8-bit mode.
- R12: While `rxEnable` is 0 the receiver is idle and no frame is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxLine | input | 1 | Serial receive line, idle high |
| baudTick | input | 1 | Oversampling strobe, 16 per bit time |
| rxEnable | input | 1 | Receiver enable |
| nineBit | input | 1 | 1 selects nine data bits per frame |
| frameChk | input | 1 | 1 enables stop-bit checking and late completion |
| addrFilter | input | 1 | 1 enables address filtering in nine-bit mode |
| slaveAddr | input | 8 | Own address |
| slaveMask | input | 8 | Address mask, 1 marks a compared bit |
| rdyClr | input | 1 | Clears `rxDone` |
| errClr | input | 1 | Clears `frameErr` |
| rxByte | output | 8 | Received byte |
| rxNinth | output | 1 | Received ninth bit |
| rxDone | output | 1 | Sticky receive-complete flag |
| frameErr | output | 1 | Sticky framing-error flag |

## Verification
The main conflict is a framing error detected in the same cycle that software clears the flag. It also appears when a frame completes in the cycle that `rdyClr` clears the complete flag. The bench provokes both by holding the clear input high across a whole frame. The flag must then appear for one cycle and fall again: a one-cycle pulse seen by the monitor shows that the set won. A flag that never rises shows that the clear won. The overrun case, where a frame arrives while `rxDone` is still set, is judged by an unchanged `rxByte` and no new completion event.

// File: rtl/urx_pkg.sv
package urx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxState_e;

  // control -> datapath
  typedef struct packed {
    logic cntStart;
    logic bitClr;
    logic shift;
    logic capture;
    logic setErr;
  } rxStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic decide;
    logic vote;
    logic lineS;
    logic lastBit;
  } rxStatus_t;

endpackage

// File: rtl/urx_addr_match.sv
module urx_addr_match #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] byteIn,
  input  logic [DATA_W-1:0] ownAddr,
  input  logic [DATA_W-1:0] ownMask,
  output logic              hit
);

  logic [DATA_W-1:0] givenOk;
  logic [DATA_W-1:0] bcastOk;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    // compared bit must equal own address; masked-off bits are free
    assign givenOk[i] = ~ownMask[i] | (byteIn[i] ~^ ownAddr[i]);
    // broadcast pattern bits that are 1 must be 1; zeros are free
    assign bcastOk[i] = ~(ownAddr[i] | ownMask[i]) | byteIn[i];
  end

  assign hit = (&givenOk) | (&bcastOk);

endmodule

// File: rtl/urx_datapath.sv
module urx_datapath
  import urx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              baudTick,
  input  logic              nineBit,
  input  logic              addrFilter,
  input  logic [DATA_W-1:0] slaveAddr,
  input  logic [DATA_W-1:0] slaveMask,
  input  logic              rdyClr,
  input  logic              errClr,
  input  rxStrobe_t         strobe,
  output rxStatus_t         status,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxNinth,
  output logic              rxDone,
  output logic              frameErr
);

  localparam int CNT_W  = $clog2(OVS);
  localparam int MID    = OVS / 2;
  localparam int WORD_W = DATA_W + 1;
  localparam int BIT_W  = $clog2(WORD_W + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lineS;
  logic [CNT_W-1:0]       tickCnt;
  logic [1:0]             early;
  logic                   vote;
  logic                   decide;
  logic [BIT_W-1:0]       bitCnt;
  logic [WORD_W-1:0]      shiftReg;
  logic [WORD_W-1:0]      frameWord;
  logic                   ninthBit;
  logic                   addrHit;
  logic                   filtered;
  logic                   accept;

  // input synchronizer, resets to idle level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
  end
  assign lineS = syncQ[SYNC_STAGES-1];

  // position inside the current bit cell
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strobe.cntStart) begin
      tickCnt <= CNT_W'(1);
    end else if (baudTick) begin
      tickCnt <= (tickCnt == CNT_W'(OVS - 1)) ? '0 : tickCnt + CNT_W'(1);
    end
  end

  // first two of the three middle samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      early <= 2'b11;
    end else if (baudTick) begin
      if (tickCnt == CNT_W'(MID - 1)) early[0] <= lineS;
      if (tickCnt == CNT_W'(MID))     early[1] <= lineS;
    end
  end

  assign decide = baudTick && (tickCnt == CNT_W'(MID + 1));
  assign vote   = (early[0] & early[1]) | (early[0] & lineS) | (early[1] & lineS);

  // data bit index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              bitCnt <= '0;
    else if (strobe.bitClr) bitCnt <= '0;
    else if (strobe.shift)  bitCnt <= bitCnt + BIT_W'(1);
  end

  // word with the bit decided this cycle merged in
  always_comb begin
    frameWord = shiftReg;
    if (strobe.shift) frameWord[bitCnt] = vote;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftReg <= '0;
    else if (strobe.shift) shiftReg <= frameWord;
  end

  assign ninthBit = nineBit & frameWord[DATA_W];

  urx_addr_match #(.DATA_W(DATA_W)) u_match (
    .byteIn  (frameWord[DATA_W-1:0]),
    .ownAddr (slaveAddr),
    .ownMask (slaveMask),
    .hit     (addrHit)
  );

  assign filtered = nineBit & addrFilter & ~(ninthBit & addrHit);
  assign accept   = ~rxDone & ~filtered;

  // delivered frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      rxNinth <= 1'b0;
    end else if (strobe.capture && accept) begin
      rxByte  <= frameWord[DATA_W-1:0];
      rxNinth <= ninthBit;
    end
  end

  // sticky flags, a set beats a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxDone   <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      if (strobe.capture && accept) rxDone <= 1'b1;
      else if (rdyClr)              rxDone <= 1'b0;
      if (strobe.setErr)            frameErr <= 1'b1;
      else if (errClr)              frameErr <= 1'b0;
    end
  end

  assign status.decide  = decide;
  assign status.vote    = vote;
  assign status.lineS   = lineS;
  assign status.lastBit = (bitCnt == (nineBit ? BIT_W'(WORD_W - 1) : BIT_W'(DATA_W - 1)));

endmodule

// File: rtl/urx_control.sv
module urx_control
  import urx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxEnable,
  input  logic      frameChk,
  input  logic      baudTick,
  input  rxStatus_t status,
  output rxStrobe_t strobe
);

  rxState_e state, stateNext;
  logic     armed, armedNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      armed <= 1'b0;
    end else begin
      state <= stateNext;
      armed <= armedNext;
    end
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    armedNext = armed;
    if (!rxEnable) begin
      stateNext = ST_IDLE;
      armedNext = 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (baudTick) begin
            if (status.lineS) begin
              armedNext = 1'b1;
            end else if (armed) begin
              strobe.cntStart = 1'b1;
              strobe.bitClr   = 1'b1;
              stateNext       = ST_START;
            end
          end
        end
        ST_START: begin
          if (status.decide) stateNext = status.vote ? ST_IDLE : ST_DATA;
        end
        ST_DATA: begin
          if (status.decide) begin
            strobe.shift = 1'b1;
            if (status.lastBit) begin
              strobe.capture = ~frameChk;
              stateNext      = ST_STOP;
            end
          end
        end
        ST_STOP: begin
          if (status.decide) begin
            strobe.capture = frameChk;
            strobe.setErr  = frameChk & ~status.vote;
            stateNext      = ST_IDLE;
            armedNext      = 1'b0;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/urx_top.sv
module urx_top
  import urx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              baudTick,
  input  logic              rxEnable,
  input  logic              nineBit,
  input  logic              frameChk,
  input  logic              addrFilter,
  input  logic [DATA_W-1:0] slaveAddr,
  input  logic [DATA_W-1:0] slaveMask,
  input  logic              rdyClr,
  input  logic              errClr,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxNinth,
  output logic              rxDone,
  output logic              frameErr
);

  rxStrobe_t strobe;
  rxStatus_t status;

  urx_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .rxEnable (rxEnable),
    .frameChk (frameChk),
    .baudTick (baudTick),
    .status   (status),
    .strobe   (strobe)
  );

  urx_datapath #(
    .OVS         (OVS),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rxLine     (rxLine),
    .baudTick   (baudTick),
    .nineBit    (nineBit),
    .addrFilter (addrFilter),
    .slaveAddr  (slaveAddr),
    .slaveMask  (slaveMask),
    .rdyClr     (rdyClr),
    .errClr     (errClr),
    .strobe     (strobe),
    .status     (status),
    .rxByte     (rxByte),
    .rxNinth    (rxNinth),
    .rxDone     (rxDone),
    .frameErr   (frameErr)
  );

endmodule

// File: rtl/urx_checker.sv
module urx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEnable,
  input logic              nineBit,
  input logic              addrFilter,
  input logic [DATA_W-1:0] slaveAddr,
  input logic [DATA_W-1:0] slaveMask,
  input logic              rdyClr,
  input logic              errClr,
  input logic [DATA_W-1:0] rxByte,
  input logic              rxNinth,
  input logic              rxDone,
  input logic              frameErr
);

  // R7
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameErr && !errClr |=> frameErr);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDone && !rdyClr |=> rxDone);

  // R8
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDone && !rdyClr |=> $stable(rxByte) && $stable(rxNinth));

  // R12
  disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable && !rxDone |=> !rxDone);

  // R2
  narrow_ninth_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDone) && !$past(nineBit) |-> !rxNinth);

  // R10
  addr_filter_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDone) && $past(nineBit) && $past(addrFilter) |->
      rxNinth &&
      ((((rxByte ^ $past(slaveAddr)) & $past(slaveMask)) == '0) ||
       ((rxByte & ($past(slaveAddr) | $past(slaveMask))) ==
        ($past(slaveAddr) | $past(slaveMask)))));

endmodule

bind urx_top urx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rxEnable   (rxEnable),
  .nineBit    (nineBit),
  .addrFilter (addrFilter),
  .slaveAddr  (slaveAddr),
  .slaveMask  (slaveMask),
  .rdyClr     (rdyClr),
  .errClr     (errClr),
  .rxByte     (rxByte),
  .rxNinth    (rxNinth),
  .rxDone     (rxDone),
  .frameErr   (frameErr)
);

// File: tb/urx_top_tb.sv
`timescale 1ns/1ps
module urx_top_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxLine = 1'b1;
  logic       baudTick = 1'b1;
  logic       rxEnable = 1'b1;
  logic       nineBit = 1'b0;
  logic       frameChk = 1'b0;
  logic       addrFilter = 1'b0;
  logic [7:0] slaveAddr = 8'h00;
  logic [7:0] slaveMask = 8'h00;
  logic       rdyClr = 1'b0;
  logic       errClr = 1'b0;
  logic [7:0] rxByte;
  logic       rxNinth;
  logic       rxDone;
  logic       frameErr;

  always #10 clk = ~clk;

  urx_top u_dut (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .baudTick(baudTick),
    .rxEnable(rxEnable), .nineBit(nineBit), .frameChk(frameChk),
    .addrFilter(addrFilter), .slaveAddr(slaveAddr), .slaveMask(slaveMask),
    .rdyClr(rdyClr), .errClr(errClr), .rxByte(rxByte), .rxNinth(rxNinth),
    .rxDone(rxDone), .frameErr(frameErr)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int startCyc = 0;
  int riseCyc = 0;
  int riseCnt = 0;
  logic prevDone = 1'b0;
  logic sawErr = 1'b0;
  logic [8:0] expQ[$];
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: pops an expected frame at every completion event
  always @(negedge clk) begin
    if (frameErr) sawErr = 1'b1;
    if (rstN && rxDone && !prevDone) begin
      riseCnt++;
      riseCyc = cyc;
      if (expQ.size() == 0) begin
        check("R8 unexpected frame delivered", {23'd0, rxNinth, rxByte}, 32'h1ff);
      end else begin
        logic [8:0] e;
        e = expQ.pop_front();
        check("R2 received frame", {23'd0, rxNinth, rxByte}, {23'd0, e});
      end
    end
    prevDone = rxDone;
  end

  // driver: queues the expected result, then drives the line
  task automatic sendFrame(input logic [8:0] word, input int nb, input logic stopVal,
                           input logic expAcc, input int glitchBit);
    if (expAcc) expQ.push_back({(nb == 9) ? word[8] : 1'b0, word[7:0]});
    @(negedge clk);
    rxLine = 1'b0;
    startCyc = cyc;
    repeat (16) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      for (int t = 0; t < 16; t++) begin
        rxLine = (glitchBit == i && t == 8) ? ~word[i] : word[i];
        @(negedge clk);
      end
    end
    rxLine = stopVal;
    repeat (16) @(negedge clk);
    rxLine = 1'b1;
    repeat (32) @(negedge clk);
  endtask

  task automatic ackDone();
    @(negedge clk); rdyClr = 1'b1;
    @(negedge clk); rdyClr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int d0, d1, n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check("R1 rxDone reset", {31'd0, rxDone}, 0);
    check("R1 frameErr reset", {31'd0, frameErr}, 0);
    check("R1 rxNinth reset", {31'd0, rxNinth}, 0);
    check("R1 rxByte reset", {24'd0, rxByte}, 0);
    repeat (20) @(negedge clk);

    // R2 / R5: 8-bit frames, stop check off
    sendFrame(9'h0A5, 8, 1'b1, 1'b1, -1);
    d0 = riseCyc - startCyc;
    ackDone();
    sendFrame(9'h03C, 8, 1'b1, 1'b1, -1);
    ackDone();

    // R5 / R6: stop check on, valid stop
    frameChk = 1'b1;
    sendFrame(9'h05A, 8, 1'b1, 1'b1, -1);
    d1 = riseCyc - startCyc;
    check("R5 completion moves by one bit time", d1 - d0, 16);
    check("R6 no error on valid stop", {31'd0, frameErr}, 0);
    ackDone();

    // R3: single deviating middle sample
    sendFrame(9'h00F, 8, 1'b1, 1'b1, 2);
    ackDone();

    // R4: false start
    n = riseCnt;
    @(negedge clk); rxLine = 1'b0;
    repeat (4) @(negedge clk);
    rxLine = 1'b1;
    repeat (40) @(negedge clk);
    check("R4 false start delivers nothing", riseCnt, n);
    sendFrame(9'h081, 8, 1'b1, 1'b1, -1);
    ackDone();

    // R6 / R7: invalid stop, then a valid frame
    sendFrame(9'h066, 8, 1'b0, 1'b1, -1);
    check("R6 framing error set", {31'd0, frameErr}, 1);
    ackDone();
    sendFrame(9'h099, 8, 1'b1, 1'b1, -1);
    check("R7 error survives valid frame", {31'd0, frameErr}, 1);
    ackDone();
    @(negedge clk); errClr = 1'b1;
    @(negedge clk); errClr = 1'b0;
    check("R7 errClr clears error", {31'd0, frameErr}, 0);

    // R7: new error in the same cycle as the clear
    sawErr = 1'b0;
    @(negedge clk); errClr = 1'b1;
    sendFrame(9'h011, 8, 1'b0, 1'b1, -1);
    check("R7 set beats clear", {31'd0, sawErr}, 1);
    errClr = 1'b0;
    @(negedge clk);
    check("R7 error cleared afterwards", {31'd0, frameErr}, 0);
    ackDone();

    // R8: overrun
    sendFrame(9'h022, 8, 1'b1, 1'b1, -1);
    n = riseCnt;
    sendFrame(9'h044, 8, 1'b1, 1'b0, -1);
    check("R8 overrun keeps byte", {24'd0, rxByte}, 32'h22);
    check("R8 overrun no new event", riseCnt, n);
    ackDone();

    // R8: completion while rdyClr is held
    n = riseCnt;
    @(negedge clk); rdyClr = 1'b1;
    sendFrame(9'h077, 8, 1'b1, 1'b1, -1);
    rdyClr = 1'b0;
    check("R8 set beats clear", riseCnt, n + 1);

    // R2: nine-bit frames, no filter
    nineBit = 1'b1;
    sendFrame(9'h1C3, 9, 1'b1, 1'b1, -1);
    check("R2 ninth bit high", {31'd0, rxNinth}, 1);
    ackDone();
    sendFrame(9'h03D, 9, 1'b1, 1'b1, -1);
    check("R2 ninth bit low", {31'd0, rxNinth}, 0);
    ackDone();

    // R9 / R10: address filtering
    addrFilter = 1'b1;
    slaveAddr = 8'h35;
    slaveMask = 8'hF0;
    n = riseCnt;
    sendFrame(9'h033, 9, 1'b1, 1'b0, -1);
    check("R9 data frame dropped", riseCnt, n);
    sendFrame(9'h13A, 9, 1'b1, 1'b1, -1);
    ackDone();
    n = riseCnt;
    sendFrame(9'h145, 9, 1'b1, 1'b0, -1);
    check("R10 mismatched address dropped", riseCnt, n);
    sendFrame(9'h1FF, 9, 1'b1, 1'b1, -1);
    ackDone();
    sendFrame(9'h1F7, 9, 1'b1, 1'b1, -1);
    check("R10 broadcast accepted", {24'd0, rxByte}, 32'hF7);
    ackDone();

    // R11: filter ignored in 8-bit mode
    nineBit = 1'b0;
    n = riseCnt;
    sendFrame(9'h045, 8, 1'b1, 1'b1, -1);
    check("R11 filter ignored", riseCnt, n + 1);
    check("R11 ninth low", {31'd0, rxNinth}, 0);
    ackDone();
    addrFilter = 1'b0;

    // R12: receiver disabled
    rxEnable = 1'b0;
    n = riseCnt;
    sendFrame(9'h012, 8, 1'b1, 1'b0, -1);
    check("R12 disabled receives nothing", riseCnt, n);
    check("R12 byte unchanged", {24'd0, rxByte}, 32'h45);
    rxEnable = 1'b1;
    repeat (4) @(negedge clk);
    sendFrame(9'h034, 8, 1'b1, 1'b1, -1);
    ackDone();

    check("R2 all expected frames delivered", expQ.size(), 0);
    finished = 1;
    summary();
  end

endmodule